// File: doc/BRIEF.md
# Oversampling UART Receiver with Majority Vote

This block receives asynchronous serial characters on a single line, timed by a tick enable that runs at sixteen times the baud rate. The line first passes a two-flop synchronizer. While idle the receiver watches the line on every tick. The first low level it sees becomes tick 0 of a candidate start bit. Three further samples are taken on ticks 7, 8 and 9. The start bit is accepted only if all three are low; otherwise the receiver goes back to hunting.

Each data bit and the stop bit are then decided by a 2-of-3 vote over three consecutive tick samples. By default these samples sit at ticks 7, 8 and 9 of the bit. When the override input is set, a programmed position P moves them to ticks P, P+1 and P+2, with P clamped to 13. Bits are assembled LSB first in an internal shift register. Once the stop bit is voted, the character is copied to a receive buffer and a full flag is raised. A read strobe clears the flag. A stop bit voted low gives a one-cycle framing-error pulse, and the character is still delivered.

Top module: `uart_ovs_rx`

## Requirements
- R1: After reset, data_o is 0x00, full_o is 0 and frame_err_o is 0.
- R2: A start bit is accepted only when the synchronized line is low on ticks 7, 8 and 9 counted from the first low tick (tick 0). If any of these three samples is high, the candidate is dropped, no character is delivered, and hunting resumes.
- R3: One bit lasts 16 ticks. Cycles with tick_i low do not advance reception, so a frame paced by a slower tick is received the same as one paced by a tick on every cycle.
- R4: With pos_ovr_i low, every data and stop bit takes the majority of the samples on its ticks 7, 8 and 9. One wrong sample leaves the bit unchanged, and two wrong samples invert it.
- R5: With pos_ovr_i high, the samples are on ticks P, P+1 and P+2, where P = pos_i for pos_i ≤ 13 and P = 13 otherwise. Line values outside that window have no effect. pos_i is ignored while pos_ovr_i is low.
- R6: Data bits are received LSB first. After the stop bit is voted, data_o holds the received byte and full_o is 1.
- R7: A cycle with rd_i high and no load in the same cycle clears full_o. data_o keeps its value.
- R8: A character that completes while full_o is 1 overwrites data_o, and full_o stays 1.
- R9: A stop bit voted low produces one cycle of frame_err_o at the load, and the byte is still delivered with full_o set. A high stop bit produces no pulse.
- R10: A line held high delivers nothing. rd_i while full_o is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial line, idle high, asynchronous |
| tick_i | input | 1 | One-cycle enable at 16x baud rate |
| pos_ovr_i | input | 1 | Selects the programmed sample position |
| pos_i | input | 4 | Programmed sample position P |
| rd_i | input | 1 | Read strobe, clears the full flag |
| data_o | output | 8 | Receive buffer |
| full_o | output | 1 | Receive buffer holds an unread byte |
| frame_err_o | output | 1 | One-cycle pulse: stop bit voted low |

## Verification
The assertions assume that tick_i is a single-cycle enable, and that pos_ovr_i and pos_i hold steady for the whole of a frame. They also assume a load is the only event that may change the buffer or raise the framing pulse. The stimulus changes the line only at tick-slot boundaries and changes the position settings only between frames, with the line idle. It raises rd_i only while tick_i is low and the line is idle. Noise is placed on exact tick positions relative to the start edge, so the expected byte follows from the vote rule alone.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned OVS = 16;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_st_e;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned POS_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_s_i,
  input  logic              ovr_i,
  input  logic [POS_W-1:0]  pos_i,
  output logic              ld_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              stop_o,
  output rx_st_e            state_o
);
  localparam int unsigned CNT_W = $clog2(OVS);
  localparam int unsigned BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] AUTO_POS = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] POS_MAX  = CNT_W'(OVS - 3);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

  rx_st_e             st_q;
  logic [CNT_W-1:0]   cnt_q, cnt_nxt;
  logic [BIT_W-1:0]   bit_q;
  logic [DATA_W-1:0]  sh_q;
  logic [1:0]         smp_q;
  logic               ld_q, stop_q;
  logic [CNT_W-1:0]   pos_clamp, base, off;
  logic               in_win, at_last, vote, start_ok;

  always_comb begin
    if (int'(pos_i) > int'(POS_MAX)) pos_clamp = POS_MAX;
    else                             pos_clamp = CNT_W'(pos_i);
    // start bit window is always the automatic one
    if (ovr_i && (st_q == ST_DATA || st_q == ST_STOP)) base = pos_clamp;
    else                                               base = AUTO_POS;
    off      = cnt_q - base;
    in_win   = (cnt_q >= base) && (off < CNT_W'(3));
    at_last  = in_win && (off == CNT_W'(2));
    vote     = (smp_q[1] & smp_q[0]) | (smp_q[1] & rx_s_i) | (smp_q[0] & rx_s_i);
    start_ok = ~(smp_q[1] | smp_q[0] | rx_s_i);
    cnt_nxt  = (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) smp_q <= '0;
    else if (tick_i && in_win) smp_q <= {smp_q[0], rx_s_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      ld_q   <= 1'b0;
      stop_q <= 1'b1;
    end else begin
      ld_q <= 1'b0;
      if (tick_i) begin
        unique case (st_q)
          ST_IDLE: begin
            if (!rx_s_i) begin
              st_q  <= ST_START;
              cnt_q <= CNT_W'(1);
            end
          end
          ST_START: begin
            cnt_q <= cnt_nxt;
            if (at_last && !start_ok) begin
              st_q <= ST_IDLE;
            end else if (cnt_q == CNT_LAST) begin
              st_q  <= ST_DATA;
              bit_q <= '0;
            end
          end
          ST_DATA: begin
            cnt_q <= cnt_nxt;
            if (at_last) sh_q <= {vote, sh_q[DATA_W-1:1]};
            if (cnt_q == CNT_LAST) begin
              if (bit_q == BIT_LAST) st_q <= ST_STOP;
              else                   bit_q <= bit_q + 1'b1;
            end
          end
          ST_STOP: begin
            cnt_q <= cnt_nxt;
            if (at_last) begin
              ld_q   <= 1'b1;
              stop_q <= vote;
              st_q   <= ST_IDLE;
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign ld_o    = ld_q;
  assign byte_o  = sh_q;
  assign stop_o  = stop_q;
  assign state_o = st_q;
endmodule

// File: rtl/uart_rx_buf.sv
module uart_rx_buf #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              stop_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              frame_err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o      <= '0;
      full_o      <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      frame_err_o <= ld_i & ~stop_i;
      if (ld_i) begin
        data_o <= byte_i;
        full_o <= 1'b1;
      end else if (rd_i) begin
        full_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_ovs_rx.sv
module uart_ovs_rx
  import uart_rx_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned POS_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              tick_i,
  input  logic              pos_ovr_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              frame_err_o
);
  logic              rx_s;
  logic              ld;
  logic [DATA_W-1:0] sh_byte;
  logic              stop_bit;
  rx_st_e            state;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  uart_rx_ctrl #(.DATA_W(DATA_W), .POS_W(POS_W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .rx_s_i (rx_s),
    .ovr_i  (pos_ovr_i),
    .pos_i  (pos_i),
    .ld_o   (ld),
    .byte_o (sh_byte),
    .stop_o (stop_bit),
    .state_o(state)
  );

  uart_rx_buf #(.DATA_W(DATA_W)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ld_i       (ld),
    .byte_i     (sh_byte),
    .stop_i     (stop_bit),
    .rd_i       (rd_i),
    .data_o     (data_o),
    .full_o     (full_o),
    .frame_err_o(frame_err_o)
  );
endmodule

// File: rtl/uart_ovs_rx_chk.sv
module uart_ovs_rx_chk
  import uart_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              rd_i,
  input logic              ld,
  input rx_st_e            state,
  input logic [DATA_W-1:0] data_o,
  input logic              full_o,
  input logic              frame_err_o
);
  AST_LOAD_SETS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld |=> full_o); // R6

  AST_LOAD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld |=> !ld); // R6

  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !ld) |=> !full_o); // R7

  AST_DATA_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld |=> $stable(data_o)); // R7

  AST_FULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld && !rd_i) |=> $stable(full_o)); // R10

  AST_FE_AT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> (full_o && $past(ld))); // R9

  AST_TICK_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(state)); // R3
endmodule

bind uart_ovs_rx uart_ovs_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .rd_i       (rd_i),
  .ld         (ld),
  .state      (state),
  .data_o     (data_o),
  .full_o     (full_o),
  .frame_err_o(frame_err_o)
);

// File: tb/tb_uart_ovs_rx.sv
`timescale 1ns/1ps
module tb_uart_ovs_rx;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_i = 1'b1;
  logic       tick_i = 1'b0;
  logic       pos_ovr_i = 1'b0;
  logic [3:0] pos_i = '0;
  logic       rd_i = 1'b0;
  logic [7:0] data_o;
  logic       full_o;
  logic       frame_err_o;

  int n_tests = 0;
  int n_fail  = 0;
  int div     = 1;
  int fe_cnt  = 0;
  bit done    = 1'b0;

  uart_ovs_rx dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_i(rx_i), .tick_i(tick_i),
    .pos_ovr_i(pos_ovr_i), .pos_i(pos_i), .rd_i(rd_i),
    .data_o(data_o), .full_o(full_o), .frame_err_o(frame_err_o)
  );

  always #5 clk_i = ~clk_i;

  always @(negedge clk_i) if (frame_err_o) fe_cnt++;

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic slot(input logic v);
    for (int c = 0; c < div; c++) begin
      @(negedge clk_i);
      rx_i   = v;
      tick_i = (c == div - 1);
    end
  endtask

  task automatic send_pat(input logic [15:0] p);
    for (int t = 0; t < 16; t++) slot(p[t]);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) slot(1'b1);
  endtask

  // mode 0: clean, 1: value only in window, 2: one wrong sample, 3: two wrong samples
  function automatic logic [15:0] bit_pat(input logic v, input int base, input int mode);
    logic [15:0] p;
    for (int t = 0; t < 16; t++) begin
      case (mode)
        1:       p[t] = (t >= base && t < base + 3) ? v : ~v;
        2:       p[t] = (t == base + 1) ? ~v : v;
        3:       p[t] = (t == base || t == base + 1) ? ~v : v;
        default: p[t] = v;
      endcase
    end
    return p;
  endfunction

  function automatic int win_base();
    if (!pos_ovr_i) return 7;
    return (pos_i > 13) ? 13 : int'(pos_i);
  endfunction

  task automatic send_frame(input logic [7:0] b, input int mode, input bit bad_stop);
    int base;
    base = win_base();
    send_pat(16'h0000);
    for (int i = 0; i < 8; i++) send_pat(bit_pat(b[i], base, mode));
    if (bad_stop) send_pat(bit_pat(1'b0, base, 1));
    else          send_pat(16'hFFFF);
    idle(8);
  endtask

  task automatic do_read();
    @(negedge clk_i);
    tick_i = 1'b0;
    rd_i   = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int fe0;
    repeat (5) @(negedge clk_i);
    // R1 reset state
    check("R1 data", data_o, 8'h00);
    check("R1 full", full_o, 0);
    check("R1 ferr", frame_err_o, 0);
    rst_ni = 1'b1;
    idle(4);

    // R6 basic frame, LSB first
    fe0 = fe_cnt;
    send_frame(8'hA5, 0, 1'b0);
    check("R6 data", data_o, 8'hA5);
    check("R6 full", full_o, 1);
    check("R9 no pulse on good stop", fe_cnt - fe0, 0);
    do_read();
    check("R7 full cleared", full_o, 0);
    check("R7 data kept", data_o, 8'hA5);
    do_read();
    check("R10 read when empty", full_o, 0);
    idle(40);
    check("R10 idle line", full_o, 0);

    // R2 short start pulses rejected: low for 7, 8, 9 ticks
    for (int k = 7; k <= 9; k++) begin
      logic [15:0] p;
      for (int t = 0; t < 16; t++) p[t] = (t < k) ? 1'b0 : 1'b1;
      send_pat(p);
      idle(200);
      check("R2 start rejected full", full_o, 0);
      check("R2 start rejected data", data_o, 8'hA5);
    end
    // R2 low on tick 8 only fails as well
    send_pat(16'hFEFF & 16'hFF00 | 16'h0180 & 16'hFEFF);
    idle(200);
    check("R2 single low sample", full_o, 0);

    // R6 exhaustive byte sweep, automatic position
    for (int b = 0; b < 256; b++) begin
      send_frame(8'(b), 0, 1'b0);
      check("R6 sweep data", data_o, b);
      check("R6 sweep full", full_o, 1);
      do_read();
    end

    // R4 vote: one wrong sample corrected, two wrong samples invert
    for (int b = 0; b < 256; b += 37) begin
      send_frame(8'(b), 2, 1'b0);
      check("R4 one bad sample", data_o, b);
      do_read();
      send_frame(8'(b), 3, 1'b0);
      check("R4 two bad samples", data_o, (~b) & 8'hFF);
      do_read();
    end
    send_frame(8'h96, 1, 1'b0);
    check("R4 auto window only", data_o, 8'h96);
    do_read();

    // R5 override position sweep including clamp
    for (int p = 0; p < 16; p++) begin
      pos_ovr_i = 1'b1;
      pos_i     = 4'(p);
      send_frame(8'(8'h3C ^ (p * 17)), 1, 1'b0);
      check("R5 override window", data_o, (8'h3C ^ (p * 17)) & 8'hFF);
      do_read();
      send_frame(8'(8'hC3 ^ p), 2, 1'b0);
      check("R5 override vote", data_o, (8'hC3 ^ p) & 8'hFF);
      do_read();
    end
    pos_ovr_i = 1'b0;
    pos_i     = 4'd2;
    send_frame(8'h5E, 1, 1'b0);
    check("R5 pos ignored when off", data_o, 8'h5E);
    do_read();

    // R3 slower tick
    div = 3;
    send_frame(8'h5A, 1, 1'b0);
    check("R3 slow tick data", data_o, 8'h5A);
    check("R3 slow tick full", full_o, 1);
    do_read();
    div = 1;

    // R8 overwrite while full
    send_frame(8'h11, 0, 1'b0);
    send_frame(8'h22, 0, 1'b0);
    check("R8 overwrite data", data_o, 8'h22);
    check("R8 overwrite full", full_o, 1);
    do_read();

    // R9 framing error
    fe0 = fe_cnt;
    send_frame(8'h7E, 0, 1'b1);
    check("R9 pulse count", fe_cnt - fe0, 1);
    check("R9 byte delivered", data_o, 8'h7E);
    check("R9 full", full_o, 1);
    do_read();

    finish_run();
  end
endmodule